// File: doc/BRIEF.md
# Multi-channel ADC sample buffer controller

This block collects conversion results for a set of analog input channels, eight by default, and holds them until software reads them. A converter-side strobe presents a channel number and a 16-bit result. The result lands in that channel's own 16-entry FIFO when the channel may take it. Each channel has a small register set: control, watermark, status, interrupt status, interrupt mask, and a data port that pops the oldest sample.

Each channel raises its own interrupt conditions: watermark reached, FIFO full and FIFO empty. Any condition that passes the channel's mask sets that channel's summary bit in a shared global interrupt status register. A global mask gates the summary bits onto one interrupt output. Software clears interrupt bits by writing ones. A bit whose cause still holds sets again at once.

A global controller-enable bit gates all sample intake. A channel can run continuously, or in snapshot mode, where it takes only a programmed number of samples after each write to its control register.

Top module: `adc_sample_buffer`

## Requirements
- R1: After reset, every control, mask, watermark, global and FIFO register reads zero, and `irq` is low.
- R2: Global registers are at 0x04, 0x0C and 0x10. Channel n's registers start at 0x800 + 0x20·n, at these offsets: 0x0 control, 0x4 watermark, 0x8 status, 0xC interrupt status, 0x10 interrupt mask, 0x14 data. Any other address reads zero.
- R3: A sample is stored only if the global enable (bit 17 at 0x04) and the channel enable (control bit 0) were both set in the cycle it arrives. It goes only to the channel named by `smp_chan`. Otherwise it has no effect.
- R4: A read of the data register returns the oldest sample in bits 15:0, with zero above, and removes it. A read of an empty channel returns zero and changes nothing.
- R5: The channel status register has three fields: bit 0 is the sticky data-lost flag, bits 8:1 are the stored entry count, and bits 16:9 always read the depth, 16.
- R6: A sample that reaches a full channel is dropped and sets data-lost, unless that channel's data register is read in the same cycle, in which case it is stored. Writing 1 to status bit 0 clears data-lost.
- R7: With control bit 1 = 0 (snapshot), a channel takes only as many samples as control bits 7:2 give, counted from its last control write. With bit 1 = 1, it takes samples without limit.
- R8: Channel interrupt status bit 0 (count ≥ watermark in bits 5:0 of the watermark register), bit 1 (count = 16) and bit 2 (count = 0) set one cycle after their condition holds. They clear by write-one, but a condition that still holds sets its bit again on the same edge.
- R9: Global status bit 9+n sets one cycle after channel n has any interrupt-status bit set that its mask (bits 2:0, same positions) also sets. It clears by write-one, and a set in the same cycle wins over the clear.
- R10: `irq` is the OR of the global status bits 16:9, each ANDed with the global mask bits 16:9 at 0x0C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (needed for the data pop) |
| reg_addr | input | 12 | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational on the address |
| smp_valid | input | 1 | Converter result strobe |
| smp_chan | input | 3 | Channel of the result |
| smp_data | input | 16 | Conversion result |
| irq | output | 1 | Combined interrupt |

## Verification
Two collisions matter most. The first is a write-one clear meeting the hardware set of the same interrupt bit. The bench clears a channel's watermark bit, and the global summary bit, while the FIFO still holds enough samples. It then expects the bit to read back set, and `irq` to stay high. The second is a data-register pop in the same cycle as a sample arriving at a full FIFO. The bench then expects the sample to be stored, the count to stay at 16 and data-lost to stay clear. A long random phase mixes both collisions with snapshot limits and mask changes. It compares every read and `irq` against the queue model on each clock.

// File: rtl/adc_buf_pkg.sv
package adc_buf_pkg;

  localparam int REG_W  = 32;
  localparam int ADDR_W = 12;

  // global register addresses
  localparam logic [ADDR_W-1:0] GLB_CTRL_ADDR = 12'h004;
  localparam logic [ADDR_W-1:0] GLB_MASK_ADDR = 12'h00C;
  localparam logic [ADDR_W-1:0] GLB_STAT_ADDR = 12'h010;
  localparam int GEN_BIT = 17;   // controller enable
  localparam int SUM_LSB = 9;    // per-channel summary field

  // channel window
  localparam logic [ADDR_W-1:0] CH_BASE = 12'h800;
  localparam int CH_STRIDE_LOG2 = 5;
  localparam int SEL_W = CH_STRIDE_LOG2 - 2;

  // channel interrupt bit positions
  localparam int IRQ_W    = 3;
  localparam int IB_WMK   = 0;
  localparam int IB_FULL  = 1;
  localparam int IB_EMPTY = 2;

  localparam int FLD_W = 8;      // status count fields

  typedef enum logic [SEL_W-1:0] {
    CR_CTL   = 3'd0,
    CR_WMK   = 3'd1,
    CR_STAT  = 3'd2,
    CR_ISTAT = 3'd3,
    CR_IMASK = 3'd4,
    CR_DATA  = 3'd5
  } chan_reg_e;

  typedef struct packed {
    logic             wr;
    logic             rd;
    logic [SEL_W-1:0] sel;
    logic [REG_W-1:0] wdata;
  } chan_req_t;

endpackage

// File: rtl/adc_buf_fifo.sv
module adc_buf_fifo #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pop,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] head,
  output logic [CNT_W-1:0]  count
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, wr_ptr_d;
  logic [PTR_W-1:0]  rd_ptr, rd_ptr_d;
  logic [CNT_W-1:0]  count_d;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_comb begin
    wr_ptr_d = push ? ptr_inc(wr_ptr) : wr_ptr;
    rd_ptr_d = pop  ? ptr_inc(rd_ptr) : rd_ptr;
    count_d  = count;
    if (push && !pop)      count_d = count + CNT_W'(1);
    else if (pop && !push) count_d = count - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      wr_ptr <= wr_ptr_d;
      rd_ptr <= rd_ptr_d;
      count  <= count_d;
    end
  end

  // storage carries no reset
  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
  end

  assign head = mem[rd_ptr];

  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

  a_r4_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> count != '0);

endmodule

// File: rtl/adc_buf_channel.sv
module adc_buf_channel
  import adc_buf_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 16,
  parameter int RND_W  = 6,
  parameter int WMK_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              glb_en,
  input  chan_req_t         req,
  input  logic              smp_req,
  input  logic [DATA_W-1:0] smp_data,
  output logic [REG_W-1:0]  rdata,
  output logic              pend
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  logic             en_q, mode_q, lost_q;
  logic [RND_W-1:0] rounds_q, taken_q, taken_d;
  logic [WMK_W-1:0] wm_q;
  logic [IRQ_W-1:0] istat_q, istat_d, imask_q, cond, clr;
  logic             lost_d;

  logic [DATA_W-1:0] head;
  logic [CNT_W-1:0]  fifo_cnt;
  logic wr_ctl, wr_wmk, wr_stat, wr_istat, wr_imask;
  logic pop, push, drop, elig, full, snap_open;
  logic unused_wdata;

  assign unused_wdata = ^req.wdata[REG_W-1:2*RND_W];

  assign wr_ctl   = req.wr && (req.sel == CR_CTL);
  assign wr_wmk   = req.wr && (req.sel == CR_WMK);
  assign wr_stat  = req.wr && (req.sel == CR_STAT);
  assign wr_istat = req.wr && (req.sel == CR_ISTAT);
  assign wr_imask = req.wr && (req.sel == CR_IMASK);

  // intake decision
  always_comb begin
    full      = (fifo_cnt == CNT_W'(DEPTH));
    pop       = req.rd && (req.sel == CR_DATA) && (fifo_cnt != '0);
    snap_open = mode_q || (taken_q < rounds_q);
    elig      = smp_req && glb_en && en_q && snap_open;
    push      = elig && (!full || pop);
    drop      = elig && full && !pop;
    taken_d   = taken_q;
    if (wr_ctl)                taken_d = '0;
    else if (elig && !mode_q)  taken_d = taken_q + RND_W'(1);
  end

  // interrupt and loss flags
  always_comb begin
    cond            = '0;
    cond[IB_WMK]    = int'(fifo_cnt) >= int'(wm_q);
    cond[IB_FULL]   = full;
    cond[IB_EMPTY]  = (fifo_cnt == '0);
    clr             = wr_istat ? req.wdata[IRQ_W-1:0] : '0;
    istat_d         = (istat_q & ~clr) | cond;
    lost_d          = (lost_q & ~(wr_stat && req.wdata[0])) | drop;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      mode_q   <= 1'b0;
      rounds_q <= '0;
      wm_q     <= '0;
      imask_q  <= '0;
      istat_q  <= '0;
      lost_q   <= 1'b0;
      taken_q  <= '0;
    end else begin
      if (wr_ctl) begin
        en_q     <= req.wdata[0];
        mode_q   <= req.wdata[1];
        rounds_q <= req.wdata[2 +: RND_W];
      end
      if (wr_wmk)   wm_q    <= req.wdata[WMK_W-1:0];
      if (wr_imask) imask_q <= req.wdata[IRQ_W-1:0];
      istat_q <= istat_d;
      lost_q  <= lost_d;
      taken_q <= taken_d;
    end
  end

  adc_buf_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push),
    .pop   (pop),
    .wdata (smp_data),
    .head  (head),
    .count (fifo_cnt)
  );

  assign pend = |(istat_q & imask_q);

  always_comb begin
    rdata = '0;
    case (req.sel)
      CR_CTL:   rdata = REG_W'({rounds_q, mode_q, en_q});
      CR_WMK:   rdata = REG_W'(wm_q);
      CR_STAT:  rdata = REG_W'({FLD_W'(DEPTH), FLD_W'(fifo_cnt), lost_q});
      CR_ISTAT: rdata = REG_W'(istat_q);
      CR_IMASK: rdata = REG_W'(imask_q);
      CR_DATA:  rdata = (fifo_cnt != '0) ? REG_W'(head) : '0;
      default:  rdata = '0;
    endcase
  end

  a_r8_wmk_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(fifo_cnt) >= int'(wm_q)) |=> istat_q[IB_WMK]);

  a_r8_full_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_cnt == CNT_W'(DEPTH)) |=> istat_q[IB_FULL]);

  a_r7_snap_closed: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_req && !mode_q && (taken_q >= rounds_q)) |=> (fifo_cnt <= $past(fifo_cnt)));

endmodule

// File: rtl/adc_sample_buffer.sv
module adc_sample_buffer
  import adc_buf_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int DEPTH  = 16,
  parameter int DATA_W = 16,
  localparam int CH_IDX_W = $clog2(NUM_CH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [REG_W-1:0]    reg_wdata,
  output logic [REG_W-1:0]    reg_rdata,
  input  logic                smp_valid,
  input  logic [CH_IDX_W-1:0] smp_chan,
  input  logic [DATA_W-1:0]   smp_data,
  output logic                irq
);

  localparam logic [ADDR_W-1:0] CH_END =
    CH_BASE + ADDR_W'(NUM_CH * (1 << CH_STRIDE_LOG2));

  // reset: asynchronous assert, synchronous release
  logic rst_s1, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s1     <= 1'b1;
      rst_sync_n <= rst_s1;
    end
  end

  logic                ch_hit;
  logic [CH_IDX_W-1:0] ch_sel;
  logic [SEL_W-1:0]    reg_sel;
  logic                unused_addr;
  logic [REG_W-1:0]    ch_rdata [NUM_CH];
  logic [NUM_CH-1:0]   ch_pend;

  logic              gen_q, gen_d;
  logic [NUM_CH-1:0] gmask_q, gmask_d, gstat_q, gstat_d, gclr;

  assign unused_addr = ^reg_addr[1:0];
  assign ch_hit  = (reg_addr >= CH_BASE) && (reg_addr < CH_END);
  assign ch_sel  = reg_addr[CH_STRIDE_LOG2 +: CH_IDX_W];
  assign reg_sel = reg_addr[CH_STRIDE_LOG2-1:2];

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    chan_req_t req_n;
    logic      hit_n;
    assign hit_n       = ch_hit && (ch_sel == CH_IDX_W'(n));
    assign req_n.wr    = reg_wr && hit_n;
    assign req_n.rd    = reg_rd && hit_n;
    assign req_n.sel   = reg_sel;
    assign req_n.wdata = reg_wdata;

    adc_buf_channel #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_ch (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .glb_en   (gen_q),
      .req      (req_n),
      .smp_req  (smp_valid && (smp_chan == CH_IDX_W'(n))),
      .smp_data (smp_data),
      .rdata    (ch_rdata[n]),
      .pend     (ch_pend[n])
    );

    a_r9_summary: assert property (@(posedge clk) disable iff (!rst_sync_n)
      ch_pend[n] |=> gstat_q[n]);
  end

  // global next state
  always_comb begin
    gen_d   = gen_q;
    gmask_d = gmask_q;
    gclr    = '0;
    if (reg_wr && reg_addr == GLB_CTRL_ADDR) gen_d   = reg_wdata[GEN_BIT];
    if (reg_wr && reg_addr == GLB_MASK_ADDR) gmask_d = reg_wdata[SUM_LSB +: NUM_CH];
    if (reg_wr && reg_addr == GLB_STAT_ADDR) gclr    = reg_wdata[SUM_LSB +: NUM_CH];
    gstat_d = (gstat_q & ~gclr) | ch_pend;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      gen_q   <= 1'b0;
      gmask_q <= '0;
      gstat_q <= '0;
    end else begin
      gen_q   <= gen_d;
      gmask_q <= gmask_d;
      gstat_q <= gstat_d;
    end
  end

  assign irq = |(gstat_q & gmask_q);

  always_comb begin
    reg_rdata = '0;
    if (ch_hit) begin
      reg_rdata = ch_rdata[ch_sel];
    end else begin
      case (reg_addr)
        GLB_CTRL_ADDR: reg_rdata = REG_W'(gen_q) << GEN_BIT;
        GLB_MASK_ADDR: reg_rdata = REG_W'(gmask_q) << SUM_LSB;
        GLB_STAT_ADDR: reg_rdata = REG_W'(gstat_q) << SUM_LSB;
        default:       reg_rdata = '0;
      endcase
    end
  end

endmodule

// File: tb/adc_sample_buffer_test.sv
`timescale 1ns/1ps
module adc_sample_buffer_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr, reg_rd;
  logic [11:0] reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        smp_valid;
  logic [2:0]  smp_chan;
  logic [15:0] smp_data;
  logic        irq;

  always #2.5 clk = ~clk;

  adc_sample_buffer uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .smp_valid(smp_valid), .smp_chan(smp_chan), .smp_data(smp_data), .irq(irq)
  );

  int    n_chk = 0;
  int    n_bad = 0;
  string cur_tag = "R1";
  int    sync_cnt = 0;

  // behavioural reference
  bit          m_gen;
  bit [7:0]    m_gmask, m_gstat;
  bit          m_en [8];
  bit          m_mode [8];
  bit [5:0]    m_rounds [8];
  bit [5:0]    m_wm [8];
  bit [2:0]    m_istat [8];
  bit [2:0]    m_imask [8];
  bit          m_lost [8];
  int          m_taken [8];
  logic [15:0] m_q [8][$];

  function automatic void m_reset();
    m_gen = 0; m_gmask = 0; m_gstat = 0;
    for (int c = 0; c < 8; c++) begin
      m_en[c] = 0; m_mode[c] = 0; m_rounds[c] = 0; m_wm[c] = 0;
      m_istat[c] = 0; m_imask[c] = 0; m_lost[c] = 0; m_taken[c] = 0;
      m_q[c].delete();
    end
  endfunction

  function automatic logic [11:0] ca(int c, int r);
    return 12'h800 + 12'(c * 32 + r * 4);
  endfunction

  function automatic logic [31:0] m_read(logic [11:0] a);
    int c, r;
    if (a >= 12'h800 && a < 12'h900) begin
      c = int'(a[7:5]); r = int'(a[4:2]);
      case (r)
        0: return {24'd0, m_rounds[c], m_mode[c], m_en[c]};
        1: return {26'd0, m_wm[c]};
        2: return {15'd0, 8'd16, 8'(m_q[c].size()), m_lost[c]};
        3: return {29'd0, m_istat[c]};
        4: return {29'd0, m_imask[c]};
        5: return (m_q[c].size() > 0) ? {16'd0, m_q[c][0]} : 32'd0;
        default: return 32'd0;
      endcase
    end
    if (a == 12'h004) return {14'd0, m_gen, 17'd0};
    if (a == 12'h00C) return {15'd0, m_gmask, 9'd0};
    if (a == 12'h010) return {15'd0, m_gstat, 9'd0};
    return 32'd0;
  endfunction

  function automatic void m_step();
    bit [2:0] cond [8];
    bit [7:0] pend, gclr;
    bit       popped [8];
    bit       drop [8];
    int       c, r, sz;
    bit       chreg;
    for (int k = 0; k < 8; k++) begin
      sz = m_q[k].size();
      cond[k] = {sz == 0, sz == 16, sz >= int'(m_wm[k])};
      pend[k] = |(m_istat[k] & m_imask[k]);
      popped[k] = 0; drop[k] = 0;
    end
    gclr = 0;
    chreg = (reg_addr >= 12'h800 && reg_addr < 12'h900);
    c = int'(reg_addr[7:5]); r = int'(reg_addr[4:2]);
    if (reg_rd && chreg && r == 5 && m_q[c].size() > 0) begin
      void'(m_q[c].pop_front()); popped[c] = 1;
    end
    if (smp_valid) begin
      int s = int'(smp_chan);
      if (m_gen && m_en[s] && (m_mode[s] || m_taken[s] < int'(m_rounds[s]))) begin
        if (!m_mode[s]) m_taken[s]++;
        if (m_q[s].size() >= 16) drop[s] = 1;
        else m_q[s].push_back(smp_data);
      end
    end
    if (reg_wr) begin
      if (chreg) begin
        case (r)
          0: begin m_en[c] = reg_wdata[0]; m_mode[c] = reg_wdata[1];
                   m_rounds[c] = reg_wdata[7:2]; m_taken[c] = 0; end
          1: m_wm[c] = reg_wdata[5:0];
          2: if (reg_wdata[0]) m_lost[c] = 0;
          3: m_istat[c] = m_istat[c] & ~reg_wdata[2:0];
          4: m_imask[c] = reg_wdata[2:0];
          default: ;
        endcase
      end else if (reg_addr == 12'h004) m_gen = reg_wdata[17];
      else if (reg_addr == 12'h00C) m_gmask = reg_wdata[16:9];
      else if (reg_addr == 12'h010) gclr = reg_wdata[16:9];
    end
    for (int k = 0; k < 8; k++) begin
      m_istat[k] = m_istat[k] | cond[k];
      if (drop[k]) m_lost[k] = 1;
    end
    m_gstat = (m_gstat & ~gclr) | pend;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_reset(); sync_cnt = 0;
    end else begin
      sync_cnt++;
      if (sync_cnt >= 3) m_step();
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      logic exp_irq;
      exp_irq = |(m_gstat & m_gmask);
      n_chk++;
      if (irq !== exp_irq) begin
        n_bad++;
        $display("FAIL R10 (%s) irq actual=%0b expected=%0b t=%0t", cur_tag, irq, exp_irq, $time);
      end
      if (reg_rd) begin
        logic [31:0] e;
        e = m_read(reg_addr);
        n_chk++;
        if (reg_rdata !== e) begin
          n_bad++;
          $display("FAIL %s read @%h actual=%h expected=%h t=%0t", cur_tag, reg_addr, reg_rdata, e, $time);
        end
      end
    end
  end

  task automatic cyc(bit wr, bit rd, logic [11:0] a, logic [31:0] d,
                     bit sv, logic [2:0] sc, logic [15:0] sd, string tag);
    @(negedge clk); #1;
    cur_tag = tag;
    reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = d;
    smp_valid = sv; smp_chan = sc; smp_data = sd;
  endtask

  task automatic wreg(logic [11:0] a, logic [31:0] d, string tag);
    cyc(1, 0, a, d, 0, 0, 0, tag);
  endtask
  task automatic rreg(logic [11:0] a, string tag);
    cyc(0, 1, a, 0, 0, 0, 0, tag);
  endtask
  task automatic smp(int c, logic [15:0] d, string tag);
    cyc(0, 0, 0, 0, 1, 3'(c), d, tag);
  endtask
  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    rst_n = 0;
    reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
    smp_valid = 0; smp_chan = 0; smp_data = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    rreg(12'h004, "R1"); rreg(12'h00C, "R1"); rreg(12'h010, "R1");
    rreg(ca(0, 0), "R1"); rreg(ca(7, 1), "R1"); rreg(ca(3, 2), "R1");
    idle(3, "R1");
    rreg(ca(0, 3), "R8 empty");
    // R2 and R3: samples before the global enable are ignored
    wreg(ca(0, 0), 32'h3, "R3");
    smp(0, 16'hAAAA, "R3");
    rreg(ca(0, 2), "R3");
    wreg(12'h004, 32'h0002_0000, "R2");
    rreg(12'h004, "R2"); rreg(12'h008, "R2"); rreg(12'h914, "R2");
    // watermark on channel 0
    wreg(ca(0, 1), 32'd3, "R8");
    wreg(ca(0, 4), 32'h1, "R9");
    wreg(12'h00C, 32'h0000_0200, "R10");
    wreg(ca(0, 3), 32'h7, "R8");
    smp(0, 16'h1111, "R8"); smp(0, 16'h2222, "R8"); idle(2, "R8");
    rreg(ca(0, 3), "R8"); rreg(12'h010, "R9");
    smp(0, 16'h3333, "R8"); idle(3, "R10");
    rreg(ca(0, 3), "R8"); rreg(12'h010, "R9");
    // R3: disabled channel and wrong channel untouched
    smp(1, 16'h5555, "R3"); idle(1, "R3");
    rreg(ca(1, 2), "R3"); rreg(ca(1, 5), "R3");
    // collision: clear while the watermark still holds
    wreg(ca(0, 3), 32'h1, "R8"); rreg(ca(0, 3), "R8");
    wreg(12'h010, 32'h0000_0200, "R9"); rreg(12'h010, "R9");
    // R4: order and empty read
    rreg(ca(0, 5), "R4"); rreg(ca(0, 5), "R4"); rreg(ca(0, 5), "R4");
    rreg(ca(0, 5), "R4"); rreg(ca(0, 2), "R5");
    idle(2, "R9");
    wreg(ca(0, 3), 32'h7, "R8"); wreg(12'h010, 32'h0001_FE00, "R9");
    idle(3, "R10"); rreg(12'h010, "R9");
    // R6: overflow on channel 2 in continuous mode
    wreg(ca(2, 0), 32'h3, "R6");
    for (int i = 0; i < 18; i++) smp(2, 16'(16'h0100 + i), "R6");
    idle(1, "R6");
    rreg(ca(2, 2), "R5"); rreg(ca(2, 3), "R8 full");
    // R6: pop and push on a full FIFO in the same cycle
    cyc(0, 1, ca(2, 5), 0, 1, 3'd2, 16'hBEEF, "R6");
    idle(1, "R6"); rreg(ca(2, 2), "R6");
    wreg(ca(2, 2), 32'h1, "R6"); rreg(ca(2, 2), "R6");
    for (int i = 0; i < 16; i++) rreg(ca(2, 5), "R4");
    rreg(ca(2, 2), "R5");
    // R7: snapshot limit of 4 on channel 3
    wreg(ca(3, 0), 32'h11, "R7");
    for (int i = 0; i < 7; i++) smp(3, 16'(16'h3000 + i), "R7");
    idle(1, "R7"); rreg(ca(3, 2), "R7");
    wreg(ca(3, 0), 32'h11, "R7");
    smp(3, 16'h3100, "R7"); smp(3, 16'h3101, "R7"); idle(1, "R7");
    rreg(ca(3, 2), "R7");
    // R3: global disable stops intake
    wreg(12'h004, 32'h0, "R3");
    smp(4, 16'h4444, "R3"); idle(1, "R3"); rreg(ca(4, 2), "R3");
    wreg(12'h004, 32'h0002_0000, "R3");
    // random mix
    for (int i = 0; i < 3000; i++) begin
      int op, c;
      op = $urandom_range(0, 13);
      c  = $urandom_range(0, 7);
      case (op)
        0, 1, 2, 3: smp(c, 16'($urandom), "rnd R3");
        4: rreg(ca(c, 5), "rnd R4");
        5: cyc(0, 1, ca(c, 5), 0, 1, 3'(c), 16'($urandom), "rnd R6");
        6: rreg(ca(c, $urandom_range(0, 7)), "rnd R5");
        7: wreg(ca(c, 0), {24'd0, 6'($urandom_range(0, 20)), 1'($urandom), 1'b1}, "rnd R7");
        8: wreg(ca(c, 1), 32'($urandom_range(0, 20)), "rnd R8");
        9: wreg(ca(c, 3), 32'($urandom_range(0, 7)), "rnd R8");
        10: wreg(ca(c, 4), 32'($urandom_range(0, 7)), "rnd R9");
        11: wreg(12'h010, {15'd0, 8'($urandom), 9'd0}, "rnd R9");
        12: wreg(12'h00C, {15'd0, 8'($urandom), 9'd0}, "rnd R10");
        default: begin rreg(12'h010, "rnd R9"); wreg(ca(c, 2), 32'h1, "rnd R6"); end
      endcase
    end
    idle(4, "R10");
    summary();
    $finish;
  end

endmodule